// File: doc/BRIEF.md
# Real-Time Clock Control and Status Registers

This block holds the four byte-wide control and status registers of a real-time clock, decoded at bus addresses 0x0A to 0x0D. Software programs the oscillator mode, the rate select, the square-wave enable, the interrupt enables and the data-format bits through a simple synchronous port. The block exports these settings as level outputs to the timekeeping core. It takes pulses from that core for update start and end, periodic events, alarm matches and update completions, and folds them into status bits and a combined interrupt line. A battery-valid level is presented as a read-only status bit.

The oscillator mode field does more than switch the oscillator. One mode runs the oscillator with the divider held off. Another mode runs like the normal mode and also unlocks writes to the flag register, so that software can turn on the 32 kHz output. When the divider comes on, the first update is held back for a programmable number of divider ticks, which stands for the half-second start-up delay. Reads are combinational. A read of the flag register clears its event flags at the clock edge that ends the read.

Top module: `rtc_ctl_regs`

## Requirements
- R1: The register at 0x0A holds the rate select in bits 3:0 (also driven on `rate_sel`), the oscillator mode in bits 6:4, and the read-only update-in-progress bit in bit 7. Writes to bit 7 are ignored. Reset leaves bits 6:0 unchanged.
- R2: Oscillator mode 010 or 011 sets both `osc_en` and `div_en`. Mode 110 or 111 sets `osc_en` with `div_en` low. Every other mode drives both low.
- R3: `upd_allow` stays low while the divider is off and after reset. It rises only once DLY_TICKS `div_tick` pulses have been seen with the divider on. Changing the rate select while the divider stays on does not lower it.
- R4: Update-in-progress (0x0A bit 7) sets on an `upd_start` pulse while `upd_allow` is high and the inhibit bit is clear, and clears on `upd_done`. An `upd_start` pulse while `upd_allow` is low is ignored.
- R5: While the update-inhibit bit (0x0B bit 7) is 1, update-in-progress reads as 0 at once, is cleared, and stays clear.
- R6: The register at 0x0B is read/write with the layout bit 7 inhibit, 6 periodic enable, 5 alarm enable, 4 update enable, 3 square-wave enable (`sqw_en`), 2 binary format (`bin_fmt`), 1 24-hour format (`hr24_fmt`), 0 daylight-saving enable (`dst_en`). Reset clears bits 6:3 and keeps bits 7 and 2:0.
- R7: The register at 0x0C reads bit 7 interrupt summary, 6 periodic flag, 5 alarm flag, 4 update flag, 2 32 kHz enable, and 0 in bits 3, 1 and 0. Each flag is set by its event pulse whatever its enable. The summary bit and `irq` are the OR of each flag ANDed with its enable in 0x0B.
- R8: A read of 0x0C clears the three flags at the clock edge that ends the read. An event arriving in that same cycle keeps its flag set.
- R9: Writes to 0x0C (bits 6:4 and bit 2) take effect only in oscillator mode 011. In every other mode they are ignored.
- R10: Reset clears the three flags and keeps the 32 kHz enable. `ck32_en` follows 0x0C bit 2.
- R11: The register at 0x0D reads `batt_ok` in bit 7 and 0 in bits 6:0, and ignores writes. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| upd_start | input | 1 | Pulse from the update engine: cycle begins |
| upd_done | input | 1 | Pulse from the update engine: cycle ended |
| upd_allow | output | 1 | First-update delay has expired and the divider is on |
| div_tick | input | 1 | Half-second divider tick pulse |
| pf_evt | input | 1 | Periodic event pulse |
| af_evt | input | 1 | Alarm match pulse |
| uf_evt | input | 1 | Update complete pulse |
| batt_ok | input | 1 | Backup battery valid level |
| osc_en | output | 1 | Oscillator enable |
| div_en | output | 1 | Divider enable |
| rate_sel | output | 4 | Rate select for the square-wave and periodic rate |
| sqw_en | output | 1 | Square-wave output enable |
| bin_fmt | output | 1 | Binary data format |
| hr24_fmt | output | 1 | 24-hour format |
| dst_en | output | 1 | Daylight-saving enable |
| ck32_en | output | 1 | 32 kHz output enable |
| irq | output | 1 | Interrupt summary |

## Verification
The hardest states to reach are the ones that sit between two mechanisms. One is an event pulse landing in the same cycle as the read that clears its flag. The bench drives the event and the read strobe together in one cycle and reads the register again afterwards. Another is the inhibit bit being raised while an update is already in progress. The bench first lets the delay counter expire with a single divider tick, starts an update, and then writes the inhibit bit. Reset retention needs the non-reset fields to hold known values first. So the bench fills every register, including the flag register (unlocked through mode 011), before it pulses reset.

// File: rtl/rtc_ctl_pkg.sv
`timescale 1ns/1ps
// Package: register addresses, oscillator mode codes and the layout of the
// control register, shared by the register file and its sub-blocks.
package rtc_ctl_pkg;

    // Register addresses (the map the software sees)
    localparam logic [7:0] ADR_MODE = 8'h0A;
    localparam logic [7:0] ADR_CTL  = 8'h0B;
    localparam logic [7:0] ADR_FLG  = 8'h0C;
    localparam logic [7:0] ADR_BAT  = 8'h0D;

    // Oscillator mode codes
    localparam logic [2:0] OSC_RUN    = 3'b010;
    localparam logic [2:0] OSC_RUN_CW = 3'b011;

    // Event flag indices inside the flag vector (bit 6 down to bit 4 of 0x0C)
    localparam int FLG_N   = 3;
    localparam int FLG_PER = 2;
    localparam int FLG_ALM = 1;
    localparam int FLG_UPD = 0;

    // Control register layout, bit 7 first
    typedef struct packed {
        logic inh;
        logic per_ie;
        logic alm_ie;
        logic upd_ie;
        logic sqw;
        logic bin;
        logic h24;
        logic dst;
    } ctl_reg_t;

endpackage

// File: rtl/rtc_osc_ctl.sv
`timescale 1ns/1ps
// Oscillator mode decode and first-update delay.
// Assumes: div_tick is a one-cycle pulse at the half-second rate.
// The counter reloads whenever the divider is off, so every off-to-on
// change of the divider starts a fresh delay.
module rtc_osc_ctl #(
    parameter int DLY_TICKS = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] osc_mode,
    input  logic       div_tick,
    output logic       osc_en,
    output logic       div_en,
    output logic       flg_wr_ok,
    output logic       upd_allow
);
    import rtc_ctl_pkg::*;

    localparam int CW = (DLY_TICKS < 1) ? 1 : $clog2(DLY_TICKS + 1);
    localparam logic [CW-1:0] LOAD = CW'(DLY_TICKS);

    logic [CW-1:0] dly_cnt;

    // Decode the mode field into the enables and the flag-write unlock
    always_comb begin
        osc_en    = 1'b0;
        div_en    = 1'b0;
        flg_wr_ok = 1'b0;
        if (osc_mode == OSC_RUN || osc_mode == OSC_RUN_CW) begin
            osc_en = 1'b1;
            div_en = 1'b1;
        end else if (osc_mode[2:1] == 2'b11) begin
            osc_en = 1'b1;
        end
        if (osc_mode == OSC_RUN_CW) begin
            flg_wr_ok = 1'b1;
        end
    end

    // Count divider ticks down to zero after the divider comes on
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_cnt <= LOAD;
        end else if (!div_en) begin
            dly_cnt <= LOAD;
        end else if (div_tick && dly_cnt != '0) begin
            dly_cnt <= dly_cnt - 1'b1;
        end
    end

    assign upd_allow = div_en && (dly_cnt == '0);

endmodule

// File: rtl/rtc_uip_track.sv
`timescale 1ns/1ps
// Update-in-progress tracker.
// Assumes: upd_start and upd_done are one-cycle pulses from the update
// engine. The inhibit input takes priority over both.
module rtc_uip_track (
    input  logic clk,
    input  logic rst_n,
    input  logic upd_start,
    input  logic upd_done,
    input  logic upd_allow,
    input  logic inhibit,
    output logic uip
);

    // Hold the in-progress bit between the start and done pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uip <= 1'b0;
        end else if (inhibit) begin
            uip <= 1'b0;
        end else if (upd_start && upd_allow) begin
            uip <= 1'b1;
        end else if (upd_done) begin
            uip <= 1'b0;
        end
    end

endmodule

// File: rtl/rtc_flag_reg.sv
`timescale 1ns/1ps
// Event flags and the 32 kHz enable of the flag register.
// Assumes: events are one-cycle pulses. Event set beats write, and write
// beats read-clear. The 32 kHz enable has no reset, so that it keeps its
// value across a reset.
module rtc_flag_reg #(
    parameter int NF = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] evt,
    input  logic          rd_clr,
    input  logic          wr_en,
    input  logic [NF-1:0] wr_flags,
    input  logic          wr_k32,
    output logic [NF-1:0] flags,
    output logic          k32
);

    for (genvar gi = 0; gi < NF; gi++) begin : g_flag
        // One sticky flag: set by its event, cleared by a read or reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[gi] <= 1'b0;
            end else if (evt[gi]) begin
                flags[gi] <= 1'b1;
            end else if (wr_en) begin
                flags[gi] <= wr_flags[gi];
            end else if (rd_clr) begin
                flags[gi] <= 1'b0;
            end
        end
    end

    // 32 kHz enable: changes only on an unlocked write
    always_ff @(posedge clk) begin
        if (wr_en) begin
            k32 <= wr_k32;
        end
    end

endmodule

// File: rtl/rtc_ctl_regs.sv
`timescale 1ns/1ps
// RTC control and status register file (0x0A..0x0D).
// Assumes: one access per strobe cycle, with read data taken before the
// closing edge. Fields that keep their value across reset have no reset term.
module rtc_ctl_regs #(
    parameter int ADDR_W    = 8,
    parameter int DLY_TICKS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              upd_start,
    input  logic              upd_done,
    output logic              upd_allow,
    input  logic              div_tick,
    input  logic              pf_evt,
    input  logic              af_evt,
    input  logic              uf_evt,
    input  logic              batt_ok,
    output logic              osc_en,
    output logic              div_en,
    output logic [3:0]        rate_sel,
    output logic              sqw_en,
    output logic              bin_fmt,
    output logic              hr24_fmt,
    output logic              dst_en,
    output logic              ck32_en,
    output logic              irq
);
    import rtc_ctl_pkg::*;

    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(ADR_MODE);
    localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(ADR_CTL);
    localparam logic [ADDR_W-1:0] A_FLG  = ADDR_W'(ADR_FLG);
    localparam logic [ADDR_W-1:0] A_BAT  = ADDR_W'(ADR_BAT);

    logic [2:0]       osc_q;
    logic [3:0]       rs_q;
    ctl_reg_t         ctl_q;
    logic             uip_q;
    logic             inh_q;
    logic             flg_wr_ok;
    logic             flg_write;
    logic             flg_rdclr;
    logic [FLG_N-1:0] evt_v;
    logic [FLG_N-1:0] ien_v;
    logic [FLG_N-1:0] flags_q;
    logic             k32_q;
    logic             intf;

    // Mode register: oscillator field and rate select, no reset
    always_ff @(posedge clk) begin
        if (bus_wr && bus_addr == A_MODE) begin
            osc_q <= bus_wdata[6:4];
            rs_q  <= bus_wdata[3:0];
        end
    end

    // Control register: reset clears only the four enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.per_ie <= 1'b0;
            ctl_q.alm_ie <= 1'b0;
            ctl_q.upd_ie <= 1'b0;
            ctl_q.sqw    <= 1'b0;
        end else if (bus_wr && bus_addr == A_CTL) begin
            ctl_q <= ctl_reg_t'(bus_wdata);
        end
    end

    assign inh_q = ctl_q.inh;

    rtc_osc_ctl #(.DLY_TICKS(DLY_TICKS)) u_osc (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_mode  (osc_q),
        .div_tick  (div_tick),
        .osc_en    (osc_en),
        .div_en    (div_en),
        .flg_wr_ok (flg_wr_ok),
        .upd_allow (upd_allow)
    );

    rtc_uip_track u_uip (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_start (upd_start),
        .upd_done  (upd_done),
        .upd_allow (upd_allow),
        .inhibit   (inh_q),
        .uip       (uip_q)
    );

    // Gather the event pulses and enables in flag-index order
    always_comb begin
        evt_v          = '0;
        ien_v          = '0;
        evt_v[FLG_PER] = pf_evt;
        evt_v[FLG_ALM] = af_evt;
        evt_v[FLG_UPD] = uf_evt;
        ien_v[FLG_PER] = ctl_q.per_ie;
        ien_v[FLG_ALM] = ctl_q.alm_ie;
        ien_v[FLG_UPD] = ctl_q.upd_ie;
    end

    assign flg_write = bus_wr && (bus_addr == A_FLG) && flg_wr_ok;
    assign flg_rdclr = bus_rd && (bus_addr == A_FLG);

    rtc_flag_reg #(.NF(FLG_N)) u_flg (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_v),
        .rd_clr   (flg_rdclr),
        .wr_en    (flg_write),
        .wr_flags (bus_wdata[6:4]),
        .wr_k32   (bus_wdata[2]),
        .flags    (flags_q),
        .k32      (k32_q)
    );

    assign intf = |(flags_q & ien_v);

    // Read multiplexer; the in-progress bit is masked at once by inhibit
    always_comb begin
        bus_rdata = 8'h00;
        unique case (bus_addr)
            A_MODE:  bus_rdata = {uip_q & ~inh_q, osc_q, rs_q};
            A_CTL:   bus_rdata = ctl_q;
            A_FLG:   bus_rdata = {intf, flags_q, 1'b0, k32_q, 2'b00};
            A_BAT:   bus_rdata = {batt_ok, 7'b0};
            default: bus_rdata = 8'h00;
        endcase
    end

    assign rate_sel = rs_q;
    assign sqw_en   = ctl_q.sqw;
    assign bin_fmt  = ctl_q.bin;
    assign hr24_fmt = ctl_q.h24;
    assign dst_en   = ctl_q.dst;
    assign ck32_en  = k32_q;
    assign irq      = intf;

endmodule

// File: rtl/rtc_ctl_regs_chk.sv
`timescale 1ns/1ps
// Checker for the register file: timing relations between the ports and
// the internal state. It is attached with the bind statement below.
module rtc_ctl_regs_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              upd_start,
    input logic              upd_allow,
    input logic              div_tick,
    input logic              osc_en,
    input logic              div_en,
    input logic              uip,
    input logic              inh,
    input logic              wr_ok,
    input logic [2:0]        evt,
    input logic [2:0]        flags,
    input logic              k32,
    input logic              irq
);
    localparam logic [ADDR_W-1:0] A_FLG = ADDR_W'(rtc_ctl_pkg::ADR_FLG);

    logic c_wr;
    assign c_wr = bus_wr && (bus_addr == A_FLG) && wr_ok;

    p_div_osc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        div_en |-> osc_en);

    p_first_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(upd_allow) |-> $past(div_tick));

    p_no_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!uip && !(upd_start && upd_allow)) |=> !uip);

    p_inh_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        inh |=> !uip);

    p_irq_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != 3'b000));

    p_rd_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_FLG && !c_wr && evt == 3'b000) |=> (flags == 3'b000));

    p_flag_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_wr && evt == 3'b000) |=> ((flags & ~$past(flags)) == 3'b000));

    p_k32_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !c_wr |=> $stable(k32));

endmodule

bind rtc_ctl_regs rtc_ctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .upd_start (upd_start),
    .upd_allow (upd_allow),
    .div_tick  (div_tick),
    .osc_en    (osc_en),
    .div_en    (div_en),
    .uip       (uip_q),
    .inh       (inh_q),
    .wr_ok     (flg_wr_ok),
    .evt       (evt_v),
    .flags     (flags_q),
    .k32       (k32_q),
    .irq       (irq)
);

// File: tb/rtc_ctl_regs_bench.sv
`timescale 1ns/1ps
// Bench: a vector table of register accesses, then directed sequences.
module rtc_ctl_regs_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       upd_start = 1'b0, upd_done = 1'b0, upd_allow, div_tick = 1'b0;
    logic       pf_evt = 1'b0, af_evt = 1'b0, uf_evt = 1'b0, batt_ok = 1'b1;
    logic       osc_en, div_en, sqw_en, bin_fmt, hr24_fmt, dst_en, ck32_en, irq;
    logic [3:0] rate_sel;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    rtc_ctl_regs u_rtc_ctl_regs (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .upd_start(upd_start), .upd_done(upd_done), .upd_allow(upd_allow),
        .div_tick(div_tick), .pf_evt(pf_evt), .af_evt(af_evt), .uf_evt(uf_evt),
        .batt_ok(batt_ok), .osc_en(osc_en), .div_en(div_en), .rate_sel(rate_sel),
        .sqw_en(sqw_en), .bin_fmt(bin_fmt), .hr24_fmt(hr24_fmt), .dst_en(dst_en),
        .ck32_en(ck32_en), .irq(irq)
    );

    // {write, requirement, address, data or expected, read mask}
    localparam int NV = 20;
    localparam logic [28:0] VEC [0:NV-1] = '{
        {1'b1, 4'd9,  8'h0A, 8'h30, 8'h00},  // R9 unlock flag writes
        {1'b1, 4'd9,  8'h0C, 8'h04, 8'h00},  // R9 set 32 kHz enable
        {1'b0, 4'd7,  8'h0C, 8'h04, 8'hFF},  // R7 layout
        {1'b1, 4'd1,  8'h0A, 8'hE5, 8'h00},  // R1 bit 7 written 1
        {1'b0, 4'd1,  8'h0A, 8'h65, 8'hFF},  // R1 bit 7 ignored
        {1'b1, 4'd9,  8'h0C, 8'h74, 8'h00},  // R9 locked write
        {1'b0, 4'd9,  8'h0C, 8'h04, 8'hFF},  // R9 no effect
        {1'b1, 4'd6,  8'h0B, 8'h7E, 8'h00},
        {1'b0, 4'd6,  8'h0B, 8'h7E, 8'hFF},  // R6 read back
        {1'b1, 4'd9,  8'h0A, 8'h30, 8'h00},
        {1'b1, 4'd7,  8'h0B, 8'h40, 8'h00},  // periodic enable only
        {1'b1, 4'd9,  8'h0C, 8'h44, 8'h00},  // set periodic flag
        {1'b0, 4'd7,  8'h0C, 8'hC4, 8'hFF},  // R7 summary bit set
        {1'b0, 4'd8,  8'h0C, 8'h04, 8'hFF},  // R8 cleared by read
        {1'b1, 4'd11, 8'h0D, 8'hFF, 8'h00},
        {1'b0, 4'd11, 8'h0D, 8'h80, 8'hFF},  // R11 read only
        {1'b0, 4'd11, 8'h05, 8'h00, 8'hFF},  // R11 unmapped
        {1'b1, 4'd9,  8'h0C, 8'h34, 8'h00},
        {1'b0, 4'd7,  8'h0C, 8'h34, 8'hFF},  // R7 flags without enables
        {1'b0, 4'd8,  8'h0C, 8'h04, 8'hFF}   // R8
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [7:0] a, input logic [7:0] m,
                         input logic [7:0] e, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #2;
        chk(tag, bus_rdata & m, e & m);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: upd_start = 1'b1;
            1: upd_done  = 1'b1;
            2: div_tick  = 1'b1;
            3: pf_evt    = 1'b1;
            4: af_evt    = 1'b1;
            default: uf_evt = 1'b1;
        endcase
        @(negedge clk);
        upd_start = 1'b0; upd_done = 1'b0; div_tick = 1'b0;
        pf_evt = 1'b0; af_evt = 1'b0; uf_evt = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state: R3 and R4
        chk("R3 allow after reset", {7'b0, upd_allow}, 8'h00);
        do_rd(8'h0A, 8'h80, 8'h00, "R4 in-progress after reset");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][28]) begin
                do_wr(VEC[i][23:16], VEC[i][15:8]);
            end else begin
                do_rd(VEC[i][23:16], VEC[i][7:0], VEC[i][15:8],
                      $sformatf("R%0d table row %0d", VEC[i][27:24], i));
            end
        end

        // R2 mode decode
        do_wr(8'h0A, 8'h20); chk("R2 mode 010", {6'b0, osc_en, div_en}, 8'h03);
        do_wr(8'h0A, 8'h30); chk("R2 mode 011", {6'b0, osc_en, div_en}, 8'h03);
        do_wr(8'h0A, 8'h60); chk("R2 mode 110", {6'b0, osc_en, div_en}, 8'h02);
        do_wr(8'h0A, 8'h70); chk("R2 mode 111", {6'b0, osc_en, div_en}, 8'h02);
        do_wr(8'h0A, 8'h40); chk("R2 mode 100", {6'b0, osc_en, div_en}, 8'h00);
        do_wr(8'h0A, 8'h00); chk("R2 mode 000", {6'b0, osc_en, div_en}, 8'h00);

        // R3 first update delay, R4 early start ignored
        do_wr(8'h0A, 8'h25);
        chk("R1 rate select", {4'b0, rate_sel}, 8'h05);
        chk("R3 held before tick", {7'b0, upd_allow}, 8'h00);
        pulse(0);
        do_rd(8'h0A, 8'h80, 8'h00, "R4 start ignored before delay");
        pulse(2);
        chk("R3 allowed after tick", {7'b0, upd_allow}, 8'h01);
        do_wr(8'h0A, 8'h2A);
        chk("R3 rate change keeps allow", {7'b0, upd_allow}, 8'h01);

        // R4 start and done
        pulse(0);
        do_rd(8'h0A, 8'hFF, 8'hAA, "R4 in progress");
        pulse(1);
        do_rd(8'h0A, 8'hFF, 8'h2A, "R4 done");

        // R5 inhibit
        pulse(0);
        do_wr(8'h0B, 8'hC0);
        do_rd(8'h0A, 8'h80, 8'h00, "R5 inhibit masks bit");
        pulse(0);
        do_rd(8'h0A, 8'h80, 8'h00, "R5 start under inhibit");
        do_wr(8'h0B, 8'h40);
        do_rd(8'h0A, 8'h80, 8'h00, "R5 stays clear after release");

        // R7 flags and summary, mode 010
        do_wr(8'h0B, 8'h20);
        pulse(3);
        chk("R7 irq periodic masked", {7'b0, irq}, 8'h00);
        do_rd(8'h0C, 8'hFF, 8'h44, "R7 periodic flag");
        pulse(4);
        chk("R7 irq alarm enabled", {7'b0, irq}, 8'h01);
        do_rd(8'h0C, 8'hFF, 8'hA4, "R7 alarm flag and summary");
        do_rd(8'h0C, 8'hFF, 8'h04, "R8 cleared");
        chk("R8 irq low after read", {7'b0, irq}, 8'h00);

        // R8 event in the read-clear cycle
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 8'h0C; uf_evt = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; uf_evt = 1'b0;
        do_rd(8'h0C, 8'hFF, 8'h14, "R8 event wins over clear");
        do_rd(8'h0C, 8'hFF, 8'h04, "R8 then cleared");

        // R9 locked write in mode 010
        do_wr(8'h0C, 8'h00);
        do_rd(8'h0C, 8'hFF, 8'h04, "R9 write ignored in 010");
        chk("R10 ck32 follows bit", {7'b0, ck32_en}, 8'h01);

        // R6 outputs
        do_wr(8'h0B, 8'h1F);
        chk("R6 outputs", {4'b0, sqw_en, bin_fmt, hr24_fmt, dst_en}, 8'h0F);

        // Reset retention: R1, R6, R10
        do_wr(8'h0A, 8'h30);
        do_wr(8'h0C, 8'h74);
        do_wr(8'h0B, 8'hFF);
        chk("R7 irq before reset", {7'b0, irq}, 8'h01);
        do_wr(8'h0A, 8'h2A);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R3 allow reloaded by reset", {7'b0, upd_allow}, 8'h00);
        chk("R6 sqw cleared", {7'b0, sqw_en}, 8'h00);
        do_rd(8'h0B, 8'hFF, 8'h87, "R6 reset keeps 7 and 2:0");
        do_rd(8'h0C, 8'hFF, 8'h04, "R10 flags cleared, 32k kept");
        do_rd(8'h0A, 8'hFF, 8'h2A, "R1 mode kept over reset");
        chk("R7 irq after reset", {7'b0, irq}, 8'h00);

        // R10 clear the 32 kHz enable through mode 011
        do_wr(8'h0A, 8'h30);
        do_wr(8'h0C, 8'h00);
        chk("R10 ck32 off", {7'b0, ck32_en}, 8'h00);
        batt_ok = 1'b0;
        do_rd(8'h0D, 8'hFF, 8'h00, "R11 battery low");

        finish_run();
    end

endmodule